// File: doc/BRIEF.md
# LIN Slave Header Receiver

This block watches a single serial receive line as a slave node on a LIN bus and decodes the three-part header that a master sends at the start of each frame. It stays deaf to the line until it sees a long dominant stretch that marks a break. It then waits for the recessive delimiter and reads the synch character. The synch character both validates the header and sets the bit period used from then on. The character after it is captured as the frame identifier.

The working bit period starts from a nominal value supplied by the host, given in clock cycles. The break threshold and the synch sampling use that nominal value. The identifier is sampled with the period measured from the synch character, so a master whose clock drifts a few percent is still read correctly. Break-seen and identifier-seen indications are sticky, and so are the synch and framing error indications. A one-cycle status-clear input drops all four.

Top module: `lin_hdr_rx`

## Requirements
- R1: The break flag `brk_flag` is set once `rxd` has stayed at 0 for `11 * nom_period` consecutive clock cycles, counted after a two-stage input synchronizer. A low stretch of only 10 nominal bit times does not set it.
- R2: Until a break has been detected, characters on the line are discarded: `id_flag` stays 0 and `id_value` is unchanged.
- R3: After the break and a recessive delimiter, the first character is the synch character. Characters are framed by a 0 start bit and a 1 stop bit, are sent LSB first and are sampled at mid-bit. When the synch character equals 0x55, `cur_period` becomes the number of cycles from the synch start-bit falling edge to the bit-7 falling edge, divided by 8. For a master sending exactly P cycles per bit, this is P.
- R4: A synch character other than 0x55 sets `sync_err`. The receiver then returns to waiting for a break, and no identifier is captured until a new break arrives.
- R5: The character after a valid synch character is sampled with `cur_period`. Once its stop bit is read, `id_value` holds that byte and `id_flag` is set.
- R6: A stop bit read as 0, in either the synch or the identifier character, sets `frame_err`. The receiver returns to waiting for a break and captures nothing.
- R7: `brk_flag`, `id_flag`, `sync_err` and `frame_err` stay set until `clr_status` is high for a cycle. A set event in the same cycle as `clr_status` wins.
- R8: A break detected at any point restarts header reception and reloads `cur_period` with `nom_period`.
- R9: After reset, all four flags are 0, `id_value` is 0 and `cur_period` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, 0 dominant |
| nom_period | input | PW | Nominal bit period in clock cycles |
| clr_status | input | 1 | Clears the sticky flags |
| brk_flag | output | 1 | Break seen (sticky) |
| id_flag | output | 1 | Identifier captured (sticky) |
| sync_err | output | 1 | Synch character was not 0x55 (sticky) |
| frame_err | output | 1 | Stop bit read as 0 (sticky) |
| id_value | output | 8 | Last captured identifier |
| cur_period | output | PW | Working bit period in clock cycles |

## Verification
The bench sends masters whose bit period is several percent off the nominal value. A receiver that kept the nominal period, or that divided the measured span wrongly, would report the wrong `cur_period` and would slip bits in the identifier. A low stretch just short of the break threshold must leave `brk_flag` clear; an off-by-one threshold would flag it. A wrong synch character followed by a plausible identifier catches a design that keeps listening after a synch error. A second break sent straight after a good synch catches a design that does not reload the nominal period when reception restarts.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_DELIM = 2'd1,
    HS_SYNC  = 2'd2,
    HS_ID    = 2'd3
  } hdr_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'h55;

  // cycles of low line needed to call a break
  function automatic int unsigned brk_limit(input int unsigned nom, input int unsigned bits);
    return nom * bits;
  endfunction

  // offset from a start edge to the middle of the start bit
  function automatic int unsigned half_of(input int unsigned p);
    return p >> 1;
  endfunction

  // eight bit times between synch start edge and bit-7 edge
  function automatic int unsigned span_to_period(input int unsigned span);
    return span >> 3;
  endfunction

endpackage

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
  parameter int PW       = 16,
  parameter int BRK_BITS = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line,
  input  logic [PW-1:0] nom_period,
  output logic          brk_evt
);
  import lin_hdr_pkg::*;

  localparam int CW = PW + 4;

  logic [CW-1:0] run_len;
  logic [CW-1:0] thr;

  assign thr = CW'(brk_limit(32'(nom_period), 32'(BRK_BITS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_len <= '0;
    else if (line)           run_len <= '0;
    else if (run_len != thr) run_len <= run_len + 1'b1;
  end

  // fires once, on the threshold-th consecutive low sample
  assign brk_evt = !line && (run_len == thr - 1'b1);

endmodule

// File: rtl/lin_char_rx.sv
module lin_char_rx #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line,
  input  logic          fall,
  input  logic          arm,
  input  logic          abort,
  input  logic [PW-1:0] period,
  output logic          rx_start,
  output logic          done,
  output logic          stop_bad,
  output logic [7:0]    data
);
  import lin_hdr_pkg::*;

  localparam logic [3:0] STOP_IDX = 4'd9;

  logic          active;
  logic [3:0]    idx;
  logic [PW-1:0] cnt;
  logic [PW-1:0] tgt;
  logic [7:0]    sh;
  logic          hit;

  assign rx_start = arm && fall && !active && !abort;
  assign hit      = active && (cnt == tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      idx      <= '0;
      cnt      <= '0;
      tgt      <= '0;
      sh       <= '0;
      done     <= 1'b0;
      stop_bad <= 1'b0;
      data     <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active <= 1'b0;
      end else if (rx_start) begin
        active <= 1'b1;
        idx    <= '0;
        cnt    <= {{(PW-1){1'b0}}, 1'b1};
        tgt    <= PW'(half_of(32'(period)));
      end else if (hit) begin
        cnt <= {{(PW-1){1'b0}}, 1'b1};
        tgt <= period;
        idx <= idx + 1'b1;
        if (idx == STOP_IDX) begin
          active   <= 1'b0;
          done     <= 1'b1;
          stop_bad <= !line;
          data     <= sh;
        end else if (idx != 4'd0) begin
          sh <= {line, sh[7:1]};
        end
      end else if (active) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lin_sync_meas.sv
module lin_sync_meas #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  logic          start,
  input  logic          stop,
  output logic [PW+2:0] span
);
  localparam int SW = PW + 3;
  // falling edges after the start edge up to bit 7 of 0x55
  localparam logic [1:0] LAST_EDGE = 2'd3;

  logic          run;
  logic [1:0]    edges;
  logic [SW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      edges <= '0;
      cnt   <= '0;
      span  <= '0;
    end else if (stop) begin
      run <= 1'b0;
    end else if (start) begin
      run   <= 1'b1;
      cnt   <= {{(SW-1){1'b0}}, 1'b1};
      edges <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
      if (fall) begin
        if (edges == LAST_EDGE) begin
          span <= cnt;
          run  <= 1'b0;
        end else begin
          edges <= edges + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lin_hdr_rx.sv
module lin_hdr_rx #(
  parameter int PW       = 16,
  parameter int BRK_BITS = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd,
  input  logic [PW-1:0] nom_period,
  input  logic          clr_status,
  output logic          brk_flag,
  output logic          id_flag,
  output logic          sync_err,
  output logic          frame_err,
  output logic [7:0]    id_value,
  output logic [PW-1:0] cur_period
);
  import lin_hdr_pkg::*;

  hdr_state_e    state;
  logic          rx_m, rx_s, rx_p;
  logic          fall;
  logic          brk_evt;
  logic          arm;
  logic [PW-1:0] samp_period;
  logic          chr_start, chr_done, chr_stop_bad;
  logic [7:0]    chr_data;
  logic [PW+2:0] span;
  logic          sync_ok_evt, sync_bad_evt, frame_evt, id_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_p <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
      rx_p <= rx_s;
    end
  end

  assign fall        = rx_p && !rx_s;
  assign arm         = (state == HS_SYNC) || (state == HS_ID);
  assign samp_period = (state == HS_ID) ? cur_period : nom_period;

  lin_brk_det #(.PW(PW), .BRK_BITS(BRK_BITS)) u_brk (
    .clk(clk), .rst_n(rst_n), .line(rx_s), .nom_period(nom_period), .brk_evt(brk_evt)
  );

  lin_char_rx #(.PW(PW)) u_chr (
    .clk(clk), .rst_n(rst_n), .line(rx_s), .fall(fall), .arm(arm), .abort(brk_evt),
    .period(samp_period), .rx_start(chr_start), .done(chr_done),
    .stop_bad(chr_stop_bad), .data(chr_data)
  );

  lin_sync_meas #(.PW(PW)) u_meas (
    .clk(clk), .rst_n(rst_n), .fall(fall),
    .start(chr_start && (state == HS_SYNC)),
    .stop(chr_done || brk_evt), .span(span)
  );

  // header events, a break overrides everything
  assign frame_evt    = chr_done && chr_stop_bad && arm && !brk_evt;
  assign sync_ok_evt  = chr_done && !chr_stop_bad && (state == HS_SYNC) &&
                        (chr_data == SYNC_BYTE) && !brk_evt;
  assign sync_bad_evt = chr_done && !chr_stop_bad && (state == HS_SYNC) &&
                        (chr_data != SYNC_BYTE) && !brk_evt;
  assign id_evt       = chr_done && !chr_stop_bad && (state == HS_ID) && !brk_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HS_IDLE;
    end else if (brk_evt) begin
      state <= HS_DELIM;
    end else begin
      unique case (state)
        HS_IDLE:  state <= HS_IDLE;
        HS_DELIM: if (rx_s) state <= HS_SYNC;
        HS_SYNC:  if (sync_ok_evt) state <= HS_ID;
                  else if (sync_bad_evt || frame_evt) state <= HS_IDLE;
        HS_ID:    if (id_evt || frame_evt) state <= HS_IDLE;
        default:  state <= HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_flag   <= 1'b0;
      id_flag    <= 1'b0;
      sync_err   <= 1'b0;
      frame_err  <= 1'b0;
      id_value   <= '0;
      cur_period <= '0;
    end else begin
      brk_flag  <= brk_evt      || (brk_flag  && !clr_status);
      id_flag   <= id_evt       || (id_flag   && !clr_status);
      sync_err  <= sync_bad_evt || (sync_err  && !clr_status);
      frame_err <= frame_evt    || (frame_err && !clr_status);
      if (id_evt) id_value <= chr_data;
      if (brk_evt)          cur_period <= nom_period;
      else if (sync_ok_evt) cur_period <= PW'(span_to_period(32'(span)));
    end
  end

endmodule

// File: rtl/lin_hdr_rx_chk.sv
module lin_hdr_rx_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_status,
  input logic [PW-1:0] nom_period,
  input logic          brk_evt,
  input logic          sync_ok_evt,
  input logic          sync_bad_evt,
  input logic          frame_evt,
  input logic          id_evt,
  input logic [7:0]    chr_data,
  input logic          brk_flag,
  input logic          id_flag,
  input logic          sync_err,
  input logic          frame_err,
  input logic [7:0]    id_value,
  input logic [PW-1:0] cur_period
);

  a_r1_brk_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_flag);

  a_r7_brk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag && !clr_status |=> brk_flag);

  a_r7_id_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    id_flag && !clr_status |=> id_flag);

  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_status && !brk_evt |=> !brk_flag);

  a_r5_id_capture: assert property (@(posedge clk) disable iff (!rst_n)
    id_evt |=> id_flag && (id_value == $past(chr_data)));

  a_r2_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !id_evt |=> $stable(id_value));

  a_r4_sync_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    sync_bad_evt |=> sync_err);

  a_r6_frame_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> frame_err);

  a_r8_period_reload: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> cur_period == $past(nom_period));

  a_r3_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_evt && !sync_ok_evt |=> $stable(cur_period));

  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sync_ok_evt, sync_bad_evt, frame_evt, id_evt}));

endmodule

bind lin_hdr_rx lin_hdr_rx_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_status(clr_status), .nom_period(nom_period),
  .brk_evt(brk_evt), .sync_ok_evt(sync_ok_evt), .sync_bad_evt(sync_bad_evt),
  .frame_evt(frame_evt), .id_evt(id_evt), .chr_data(chr_data),
  .brk_flag(brk_flag), .id_flag(id_flag), .sync_err(sync_err),
  .frame_err(frame_err), .id_value(id_value), .cur_period(cur_period)
);

// File: tb/lin_hdr_rx_bench.sv
module lin_hdr_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW  = 16;
  localparam int NOM = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rxd = 1'b1;
  logic [PW-1:0] nom_period = PW'(NOM);
  logic          clr_status = 1'b0;
  logic          brk_flag, id_flag, sync_err, frame_err;
  logic [7:0]    id_value;
  logic [PW-1:0] cur_period;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_hdr_rx #(.PW(PW)) u_lin_hdr_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .nom_period(nom_period),
    .clr_status(clr_status), .brk_flag(brk_flag), .id_flag(id_flag),
    .sync_err(sync_err), .frame_err(frame_err), .id_value(id_value),
    .cur_period(cur_period)
  );

  // expected period: eight measured bit times, divided back by eight
  function automatic int exp_period(input int p);
    int span;
    span = 8 * p;
    return span / 8;
  endfunction

  // line level of bit position k of a framed character
  function automatic logic frame_bit(input logic [7:0] b, input int k, input logic stop);
    if (k == 0) return 1'b0;
    if (k == 9) return stop;
    return b[k-1];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] b, input int p, input logic stop);
    for (int k = 0; k < 10; k++) hold(frame_bit(b, k, stop), p);
  endtask

  task automatic clear_flags();
    @(negedge clk) clr_status = 1'b1;
    @(negedge clk) clr_status = 1'b0;
  endtask

  task automatic header(input int p, input logic [7:0] id);
    hold(1'b0, 13 * p);
    hold(1'b1, p);
    send_char(8'h55, p, 1'b1);
    hold(1'b1, int'($urandom_range(0, 5)) + 1);
    send_char(id, p, 1'b1);
    hold(1'b1, 20);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset values
    chk("R9 brk_flag", int'(brk_flag), 0);
    chk("R9 id_flag", int'(id_flag), 0);
    chk("R9 sync_err", int'(sync_err), 0);
    chk("R9 frame_err", int'(frame_err), 0);
    chk("R9 id_value", int'(id_value), 0);
    chk("R9 cur_period", int'(cur_period), 0);

    // R2 characters with no break before them are dropped
    send_char(8'h55, NOM, 1'b1);
    send_char(8'h3C, NOM, 1'b1);
    hold(1'b1, 30);
    chk("R2 id_flag", int'(id_flag), 0);
    chk("R2 id_value", int'(id_value), 0);

    // R1 ten bit times low is not a break
    hold(1'b0, 10 * NOM);
    hold(1'b1, 30);
    chk("R1 short low", int'(brk_flag), 0);

    // R1 just over eleven bit times is a break; R8 period reload
    hold(1'b0, 11 * NOM + 6);
    chk("R1 break flag", int'(brk_flag), 1);
    chk("R8 period nominal", int'(cur_period), NOM);
    hold(1'b1, NOM);

    // R4 wrong synch, then an identifier-looking byte
    send_char(8'h54, NOM, 1'b1);
    hold(1'b1, 10);
    chk("R4 sync_err", int'(sync_err), 1);
    send_char(8'h12, NOM, 1'b1);
    hold(1'b1, 20);
    chk("R4 no id_flag", int'(id_flag), 0);
    chk("R4 id_value kept", int'(id_value), 0);
    hold(1'b1, 200);
    chk("R7 brk sticky", int'(brk_flag), 1);
    chk("R7 sync_err sticky", int'(sync_err), 1);
    clear_flags();
    @(negedge clk);
    chk("R7 brk cleared", int'(brk_flag), 0);
    chk("R7 sync_err cleared", int'(sync_err), 0);

    // R6 identifier with a low stop bit; R3 period from synch
    hold(1'b0, 13 * 102);
    hold(1'b1, 102);
    send_char(8'h55, 102, 1'b1);
    hold(1'b1, 2);
    chk("R3 measured period", int'(cur_period), exp_period(102));
    send_char(8'hA5, 102, 1'b0);
    hold(1'b1, 20);
    chk("R6 frame_err", int'(frame_err), 1);
    chk("R6 no id_flag", int'(id_flag), 0);
    clear_flags();
    @(negedge clk);
    chk("R7 frame_err cleared", int'(frame_err), 0);

    // R8 break right after a good synch restarts reception
    hold(1'b0, 13 * 104);
    hold(1'b1, 104);
    send_char(8'h55, 104, 1'b1);
    hold(1'b1, 3);
    chk("R3 period 104", int'(cur_period), exp_period(104));
    hold(1'b0, 13 * 97);
    chk("R8 reload on break", int'(cur_period), NOM);
    hold(1'b1, 97);
    send_char(8'h55, 97, 1'b1);
    hold(1'b1, 2);
    send_char(8'h3B, 97, 1'b1);
    hold(1'b1, 20);
    chk("R8 id after restart", int'(id_value), 8'h3B);
    chk("R5 id_flag", int'(id_flag), 1);
    chk("R3 period 97", int'(cur_period), exp_period(97));
    clear_flags();
    @(negedge clk);
    chk("R7 id_flag cleared", int'(id_flag), 0);

    // R3 R5 random masters within a few percent of nominal
    for (int it = 0; it < 12; it++) begin
      int p;
      logic [7:0] id;
      p  = int'($urandom_range(96, 104));
      id = 8'($urandom);
      header(p, id);
      chk("R5 random id", int'(id_value), int'(id));
      chk("R5 random id_flag", int'(id_flag), 1);
      chk("R3 random period", int'(cur_period), exp_period(p));
      chk("R4 random no sync_err", int'(sync_err), 0);
      clear_flags();
    end

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule